// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two direction predictors side by side and a chooser picks one of them. The first predictor is per-branch: ten PC bits select a stored 10-bit history of that branch's own past outcomes. That history then selects a 3-bit saturating counter. The second predictor is path-based: a 12-bit register of the most recent outcomes of all branches selects a 2-bit saturating counter. The same 12-bit register also selects a 2-bit chooser counter. The chooser decides which of the two component guesses becomes the final answer.

A lookup is requested with a valid strobe and the low PC bits. One clock later the block returns the final guess and both component guesses. The caller keeps the component guesses and hands them back on the update port, together with the branch PC and the resolved outcome. On an update the component counters are trained toward the outcome. The chooser is trained only when the two components disagreed. The outcome is shifted into the path history and into that branch's own history. Updates are applied in program order and nothing is repaired speculatively.

Top module: `tourn_pred`

## Requirements
- R1: After reset every stored history, including the path history, is all zeros. Every 3-bit counter holds 3 and every 2-bit counter (component and chooser) holds 1, which is the weakly not-taken state. The first lookup after reset therefore returns 0 on all three guesses, and all outputs read 0 before any lookup.
- R2: A lookup presented with `pred_valid_i` high at a clock edge appears on the outputs after that edge, with `pred_valid_o` high for exactly that one cycle. While `pred_valid_o` is low, `pred_taken_o`, `pred_local_o` and `pred_global_o` are all 0.
- R3: `pred_local_o` is 1 when the 3-bit counter is 4 or more. That counter is the one selected by the 10-bit history stored for `pred_pc_i`.
- R4: `pred_global_o` is 1 when the 2-bit counter is 2 or more. That counter is the one selected by the 12-bit path history.
- R5: `pred_taken_o` equals `pred_global_o` when the chooser counter at the path-history index is 2 or more, and equals `pred_local_o` otherwise.
- R6: On an update, the per-branch counter (at the stored history of `upd_pc_i`) and the path counter (at the current path history) each move one step toward the outcome. They saturate at 0 and at their maximum (7 and 3).
- R7: On an update where `upd_local_i` differs from `upd_global_i`, the chooser counter at the current path history steps up if `upd_global_i` equals `upd_taken_i` and steps down otherwise, saturating at 0 and 3. When the two are equal, the chooser is left unchanged.
- R8: Each update shifts the outcome into bit 0 of the path history, and the oldest bit drops out. Without an update the path history holds its value.
- R9: Each update shifts the outcome into bit 0 of the history stored for `upd_pc_i` only. The histories of other branches are left unchanged.
- R10: When a lookup and an update happen in the same cycle, the lookup sees the tables and histories as they were before that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_valid_i | input | 1 | Lookup request strobe |
| pred_pc_i | input | 10 | Low PC bits of the branch to predict |
| pred_valid_o | output | 1 | Lookup result valid |
| pred_taken_o | output | 1 | Final taken guess |
| pred_local_o | output | 1 | Guess from the per-branch component |
| pred_global_o | output | 1 | Guess from the path-history component |
| upd_valid_i | input | 1 | Training strobe |
| upd_pc_i | input | 10 | Low PC bits of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| upd_local_i | input | 1 | Per-branch guess that was returned for this branch |
| upd_global_i | input | 1 | Path-history guess that was returned for this branch |

## Verification
A lookup and a training update can land in the same clock. They can even target the same branch, and they always share the path-history index. The stimulus provokes this on purpose, in directed runs that look up and train one PC in the same cycle, and in random traffic over a small pool of PCs. A behavioural model in the bench forms each expected guess from its state before it applies that cycle's update. Each result is compared one cycle later. A lookup that saw post-update counters or histories therefore shows up as a mismatch.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

    typedef enum logic {
        SRC_LOCAL  = 1'b0,
        SRC_GLOBAL = 1'b1
    } src_e;

    function automatic logic pick_guess(src_e src, logic loc, logic glb);
        return (src == SRC_GLOBAL) ? glb : loc;
    endfunction

endpackage

// File: rtl/tp_table.sv
module tp_table #(
    parameter int               IDX_W   = 10,
    parameter int               DAT_W   = 2,
    parameter logic [DAT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [DAT_W-1:0] rd_a_dat,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [DAT_W-1:0] rd_b_dat,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DAT_W-1:0] wr_dat
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DAT_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= RST_VAL;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_dat;
        end
    end

    assign rd_a_dat = mem_q[rd_a_idx];
    assign rd_b_dat = mem_q[rd_b_idx];

endmodule

// File: rtl/tp_sat_ctr.sv
module tp_sat_ctr #(
    parameter int W = 2
) (
    input  logic [W-1:0] cur_i,
    input  logic         up_i,
    output logic [W-1:0] nxt_o
);
    localparam logic [W-1:0] CEIL = '1;

    always_comb begin
        nxt_o = cur_i;
        if (up_i) begin
            if (cur_i != CEIL) nxt_o = cur_i + W'(1);
        end else begin
            if (cur_i != '0) nxt_o = cur_i - W'(1);
        end
    end

endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
    import tourn_pkg::*;
#(
    parameter int PC_W = 10,
    parameter int LH_W = 10,
    parameter int LC_W = 3,
    parameter int GH_W = 12,
    parameter int GC_W = 2,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pred_valid_i,
    input  logic [PC_W-1:0] pred_pc_i,
    output logic            pred_valid_o,
    output logic            pred_taken_o,
    output logic            pred_local_o,
    output logic            pred_global_o,
    input  logic            upd_valid_i,
    input  logic [PC_W-1:0] upd_pc_i,
    input  logic            upd_taken_i,
    input  logic            upd_local_i,
    input  logic            upd_global_i
);
    // weakly not-taken = just below the half point; taken = at or above half
    localparam logic [LC_W-1:0] LC_HALF = LC_W'(1) << (LC_W - 1);
    localparam logic [GC_W-1:0] GC_HALF = GC_W'(1) << (GC_W - 1);
    localparam logic [CH_W-1:0] CH_HALF = CH_W'(1) << (CH_W - 1);
    localparam logic [LC_W-1:0] LC_WEAK = LC_HALF - LC_W'(1);
    localparam logic [GC_W-1:0] GC_WEAK = GC_HALF - GC_W'(1);
    localparam logic [CH_W-1:0] CH_WEAK = CH_HALF - CH_W'(1);

    typedef struct packed {
        logic            vld;
        logic            taken;
        logic            loc;
        logic            glb;
        logic [GH_W-1:0] ghr;
    } state_t;

    state_t st_d, st_q;
    logic [GH_W-1:0] ghr_q;

    logic [LH_W-1:0] lh_pred, lh_upd, lh_new;
    logic [LC_W-1:0] lc_pred, lc_upd, lc_nxt;
    logic [GC_W-1:0] gc_pred, gc_upd, gc_nxt;
    logic [CH_W-1:0] ch_pred, ch_upd, ch_nxt;
    logic            ch_wr, ch_up;

    assign ghr_q  = st_q.ghr;
    assign lh_new = {lh_upd[LH_W-2:0], upd_taken_i};
    assign ch_wr  = upd_valid_i && (upd_local_i != upd_global_i);
    assign ch_up  = (upd_global_i == upd_taken_i);

    // per-branch history table
    tp_table #(.IDX_W(PC_W), .DAT_W(LH_W), .RST_VAL('0)) u_lht (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(pred_pc_i), .rd_a_dat(lh_pred),
        .rd_b_idx(upd_pc_i),  .rd_b_dat(lh_upd),
        .wr_en(upd_valid_i), .wr_idx(upd_pc_i), .wr_dat(lh_new)
    );

    // per-branch counters, selected by history
    tp_table #(.IDX_W(LH_W), .DAT_W(LC_W), .RST_VAL(LC_WEAK)) u_lct (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(lh_pred), .rd_a_dat(lc_pred),
        .rd_b_idx(lh_upd),  .rd_b_dat(lc_upd),
        .wr_en(upd_valid_i), .wr_idx(lh_upd), .wr_dat(lc_nxt)
    );

    // path-history counters
    tp_table #(.IDX_W(GH_W), .DAT_W(GC_W), .RST_VAL(GC_WEAK)) u_gct (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(ghr_q), .rd_a_dat(gc_pred),
        .rd_b_idx(ghr_q), .rd_b_dat(gc_upd),
        .wr_en(upd_valid_i), .wr_idx(ghr_q), .wr_dat(gc_nxt)
    );

    // chooser counters
    tp_table #(.IDX_W(GH_W), .DAT_W(CH_W), .RST_VAL(CH_WEAK)) u_cht (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(ghr_q), .rd_a_dat(ch_pred),
        .rd_b_idx(ghr_q), .rd_b_dat(ch_upd),
        .wr_en(ch_wr), .wr_idx(ghr_q), .wr_dat(ch_nxt)
    );

    tp_sat_ctr #(.W(LC_W)) u_lc_step (.cur_i(lc_upd), .up_i(upd_taken_i), .nxt_o(lc_nxt));
    tp_sat_ctr #(.W(GC_W)) u_gc_step (.cur_i(gc_upd), .up_i(upd_taken_i), .nxt_o(gc_nxt));
    tp_sat_ctr #(.W(CH_W)) u_ch_step (.cur_i(ch_upd), .up_i(ch_up),       .nxt_o(ch_nxt));

    always_comb begin
        src_e pick;
        st_d       = st_q;
        pick       = (ch_pred >= CH_HALF) ? SRC_GLOBAL : SRC_LOCAL;
        st_d.vld   = pred_valid_i;
        st_d.loc   = 1'b0;
        st_d.glb   = 1'b0;
        st_d.taken = 1'b0;
        if (pred_valid_i) begin
            st_d.loc   = (lc_pred >= LC_HALF);
            st_d.glb   = (gc_pred >= GC_HALF);
            st_d.taken = pick_guess(pick, st_d.loc, st_d.glb);
        end
        if (upd_valid_i) begin
            st_d.ghr = {st_q.ghr[GH_W-2:0], upd_taken_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pred_valid_o  = st_q.vld;
    assign pred_taken_o  = st_q.taken;
    assign pred_local_o  = st_q.loc;
    assign pred_global_o = st_q.glb;

endmodule

// File: rtl/tourn_pred_chk.sv
module tourn_pred_chk #(
    parameter int GH_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pred_valid_i,
    input logic            pred_valid_o,
    input logic            pred_taken_o,
    input logic            pred_local_o,
    input logic            pred_global_o,
    input logic            upd_valid_i,
    input logic            upd_taken_i,
    input logic [GH_W-1:0] ghr
);
    p_req_to_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_i |=> pred_valid_o);

    p_no_req_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid_i |=> !pred_valid_o);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid_o |-> (!pred_taken_o && !pred_local_o && !pred_global_o));

    p_agree_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid_o && (pred_local_o == pred_global_o)) |-> (pred_taken_o == pred_local_o));

    p_pick_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_o |-> ((pred_taken_o == pred_local_o) || (pred_taken_o == pred_global_o)));

    p_ghr_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_i |=> ((ghr[0] == $past(upd_taken_i)) &&
                         (ghr[GH_W-1:1] == $past(ghr[GH_W-2:0]))));

    p_ghr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid_i |=> $stable(ghr));

endmodule

bind tourn_pred tourn_pred_chk #(.GH_W(GH_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .pred_valid_i(pred_valid_i), .pred_valid_o(pred_valid_o),
    .pred_taken_o(pred_taken_o), .pred_local_o(pred_local_o),
    .pred_global_o(pred_global_o),
    .upd_valid_i(upd_valid_i), .upd_taken_i(upd_taken_i),
    .ghr(ghr_q)
);

// File: tb/tourn_pred_bench.sv
module tourn_pred_bench;
    localparam int NPC = 1024;
    localparam int NLH = 1024;
    localparam int NGH = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pred_valid_i = 1'b0;
    logic [9:0] pred_pc_i = '0;
    logic       pred_valid_o, pred_taken_o, pred_local_o, pred_global_o;
    logic       upd_valid_i = 1'b0;
    logic [9:0] upd_pc_i = '0;
    logic       upd_taken_i = 1'b0;
    logic       upd_local_i = 1'b0;
    logic       upd_global_i = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    tourn_pred u_tourn_pred (
        .clk(clk), .rst_n(rst_n),
        .pred_valid_i(pred_valid_i), .pred_pc_i(pred_pc_i),
        .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o),
        .pred_local_o(pred_local_o), .pred_global_o(pred_global_o),
        .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i),
        .upd_taken_i(upd_taken_i), .upd_local_i(upd_local_i),
        .upd_global_i(upd_global_i)
    );

    // behavioural reference state
    int m_lht [NPC];
    int m_lct [NLH];
    int m_gct [NGH];
    int m_cht [NGH];
    int m_ghr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    bit    have_exp = 0;
    bit    e_v, e_t, e_l, e_g;
    string e_tag;

    function automatic bit m_loc(int pc);
        return m_lct[m_lht[pc]] >= 4;
    endfunction

    function automatic bit m_glb();
        return m_gct[m_ghr] >= 2;
    endfunction

    function automatic bit m_final(int pc);
        return (m_cht[m_ghr] >= 2) ? m_glb() : m_loc(pc);
    endfunction

    function automatic int sat(int v, bit up, int top);
        if (up) return (v < top) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    function automatic void m_train(int pc, bit t, bit ul, bit ug);
        int h;
        h = m_lht[pc];
        m_lct[h] = sat(m_lct[h], t, 7);
        m_gct[m_ghr] = sat(m_gct[m_ghr], t, 3);
        if (ul != ug) m_cht[m_ghr] = sat(m_cht[m_ghr], ug == t, 3);
        m_lht[pc] = ((h << 1) | int'(t)) % NLH;
        m_ghr = ((m_ghr << 1) | int'(t)) % NGH;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // compare previous cycle, then drive this cycle and advance the model
    task automatic step(bit pv, int ppc, bit uv, int upc, bit ut, string tag);
        bit ul, ug;
        if (have_exp) begin
            check(pred_valid_o == e_v, {"R2 ", e_tag}, "valid", pred_valid_o, e_v);
            check(pred_local_o == e_l, {"R3 ", e_tag}, "local", pred_local_o, e_l);
            check(pred_global_o == e_g, {"R4 ", e_tag}, "global", pred_global_o, e_g);
            check(pred_taken_o == e_t, {"R5 ", e_tag}, "taken", pred_taken_o, e_t);
        end
        // R10: expectation taken from the state before this cycle's update
        e_v = pv;
        e_l = pv ? m_loc(ppc) : 1'b0;
        e_g = pv ? m_glb() : 1'b0;
        e_t = pv ? m_final(ppc) : 1'b0;
        e_tag = tag;
        have_exp = 1;
        ul = m_loc(upc);
        ug = m_glb();
        if (uv) m_train(upc, ut, ul, ug);
        pred_valid_i = pv;
        pred_pc_i    = 10'(ppc);
        upd_valid_i  = uv;
        upd_pc_i     = 10'(upc);
        upd_taken_i  = ut;
        upd_local_i  = ul;
        upd_global_i = ug;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int pool [8];
        int pat  [8];
        for (int i = 0; i < NPC; i++) m_lht[i] = 0;
        for (int i = 0; i < NLH; i++) m_lct[i] = 3;
        for (int i = 0; i < NGH; i++) begin m_gct[i] = 1; m_cht[i] = 1; end
        m_ghr = 0;
        void'($urandom(32'h5eed));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check(pred_valid_o == 0, "R1", "valid", pred_valid_o, 0);
        check(pred_taken_o == 0, "R1", "taken", pred_taken_o, 0);
        check(pred_local_o == 0, "R1", "local", pred_local_o, 0);
        check(pred_global_o == 0, "R1", "global", pred_global_o, 0);

        // R1: first lookups see weak not-taken everywhere
        step(1, 5, 0, 0, 0, "R1");
        step(1, 1023, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, "R2");

        // R6: saturate toward taken, then toward not-taken (lookup + train same PC, R10)
        for (int i = 0; i < 20; i++) step(1, 3, 1, 3, 1, "R6 R10");
        for (int i = 0; i < 4; i++) step(1, 3, 0, 0, 0, "R6");
        for (int i = 0; i < 20; i++) step(1, 3, 1, 3, 0, "R6 R10");
        for (int i = 0; i < 4; i++) step(1, 3, 0, 0, 0, "R6");

        // R9: train one branch, look up another whose history must stay put
        for (int i = 0; i < 12; i++) step(1, 200, 1, 100, 1, "R9");
        for (int i = 0; i < 6; i++) step(1, 100, 0, 0, 0, "R9");

        // R8: path history moves only on updates
        for (int i = 0; i < 8; i++) step(1, 7, (i % 2) == 0, 9, (i % 3) == 0, "R8");

        // R7: periodic per-branch pattern drives components apart
        for (int i = 0; i < 600; i++) begin
            int pc;
            pc = (i % 3 == 0) ? 40 : 41;
            step(1, pc, 1, pc, (i % 7) != 3, "R7");
        end

        // random mix with overlapping lookup and training (R10)
        for (int i = 0; i < 8; i++) begin
            pool[i] = int'($urandom_range(1023, 0));
            pat[i]  = int'($urandom_range(255, 1));
        end
        for (int i = 0; i < 4000; i++) begin
            int a, b;
            bit t;
            a = int'($urandom_range(7, 0));
            b = int'($urandom_range(7, 0));
            if ($urandom_range(3, 0) == 0) b = a;
            t = (i % 5 == 0) ? 1'($urandom_range(1, 0)) : 1'(pat[b] >> (i % 8));
            step($urandom_range(3, 0) != 0, pool[a], $urandom_range(3, 0) != 0,
                 pool[b], t, "R10");
        end

        step(0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R2");
        done = 1;
        summary();
        $finish;
    end

endmodule